// File: doc/BRIEF.md
# Receive Descriptor Ring Scatter Engine

This block takes incoming Ethernet frames one byte at a time and writes them into memory buffers named by a ring of receive descriptors. Each frame is followed in memory by its 4-byte CRC-32 check sequence, which the block computes as the bytes arrive. When one buffer is full, the block moves on to the next descriptor. The CRC bytes count toward the frame size and may be split between two buffers. When the block finishes a buffer, it writes that buffer's length back into the descriptor and clears the descriptor's empty flag. The final descriptor of a frame also receives the last flag and any length error flags. Two event bits report the result, and they are combined with a mask into one interrupt line.

Software sets up the ring base, the per-buffer byte limit, a receive control word and an option that inserts a two-byte zero pad. Software then writes the receive-active register. The engine accepts a frame only while receive-active is set. After each frame, receive-active is re-evaluated from the empty flag of the next descriptor.

Each descriptor is two 32-bit words. Word 0 holds the flags in bits 31:16 and the length in bits 15:0. Within word 0, bit 31 is empty, bit 29 is wrap, bit 27 is last, bit 21 is length violation and bit 16 is truncated. Word 1 holds the byte address of the buffer. Registers sit at word addresses 0 to 6: 0 ring base, 1 buffer size, 2 receive control, 3 receive active (read bit 24), 4 events (bit 25 frame done, bit 24 buffer done), 5 event mask (same bits) and 6 options (bit 0 enables the pad).

Top module: `rx_ring_engine`

## Requirements
- R1: After reset, the registers read as follows: receive control 0x05EE0001, buffer size 0x600, receive active 0, events 0. The interrupt output is low.
- R2: A write to the buffer size register keeps only bits 13:4. A write to the ring base register clears bits 2:0, and the descriptor pointer is set to the new base.
- R3: The frame size is the payload length plus 4. After the payload, the block writes the inverted reflected CRC-32 of the payload (polynomial 0xEDB88320, starting value all ones), lowest byte first. These 4 bytes may be split across the last two buffers.
- R4: No buffer receives more bytes than the buffer size register allows. When the block finishes a buffer, it writes the used length into word 0 bits 15:0, clears bit 31 and leaves the other flag bits unchanged.
- R5: The final descriptor of a frame also gets bit 27 set, together with the frame's error bits, and sets event bit 25. Every other finished descriptor sets event bit 24.
- R6: A frame larger than MAX_FRAME is cut to MAX_FRAME bytes. Its buffers hold the first MAX_FRAME-4 bytes and then the 4 CRC bytes, and the final descriptor has both bit 16 and bit 21 set.
- R7: If the frame size after any cut exceeds receive control bits 31:16, only bit 21 is set.
- R8: When option bit 0 is set, two zero bytes are written at the start of the first buffer only, and the frame size grows by 2.
- R9: After finishing a descriptor whose wrap bit 29 is set, the pointer returns to the ring base. Otherwise it advances by 8 bytes.
- R10: If the next descriptor is not empty in the middle of a frame, the rest of the frame is dropped. No final descriptor is written and event bit 25 is not set.
- R11: At the end of every frame, receive active is set to the empty bit of the descriptor at the pointer. A write to receive active while it is clear re-reads that descriptor in the same way.
- R12: A frame that arrives while receive active is clear is consumed and discarded. Memory and the event register are left unchanged.
- R13: Writing a 1 to an event bit clears that bit. The interrupt output is high exactly when some event bit is set and its mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame byte is offered |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Offered byte ends the frame |
| in_ready | output | 1 | The byte is taken at this edge |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data (a data byte is repeated on all lanes) |
| mem_be | output | 4 | Byte enables of a write |
| mem_ack | input | 1 | Access completes at this edge |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq_o | output | 1 | Masked receive interrupt |

## Verification
Register reads and the interrupt line depend only on stored state, so they are sampled half a cycle after the write that changes them. Memory results depend on how quickly the memory acknowledges, and acknowledges arrive at random times. For that reason the bench compares the whole memory image, the event register and receive active only after a frame's last byte has been accepted and a fixed settling window of 300 cycles has passed. That window covers the CRC bytes, the descriptor close-out and the re-arm read several times over. Byte acceptance is decided from in_ready sampled between clock edges, so every transfer is counted at the edge where it happens.

// File: rtl/rx_ring_engine.sv
module rx_ring_engine #(
  parameter int MAX_FRAME = 2032,
  parameter int CW        = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        in_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_o
);
  localparam logic [2:0] A_BASE = 3'd0, A_BUFSZ = 3'd1, A_CTRL = 3'd2, A_ACT = 3'd3,
                         A_EVT = 3'd4, A_MASK = 3'd5, A_OPT = 3'd6;
  localparam int B_E = 31, B_W = 29;
  localparam logic [31:0] M_E = 32'h8000_0000, M_L = 32'h0800_0000,
                          M_LG = 32'h0020_0000, M_TR = 32'h0001_0000;
  localparam logic [CW-1:0] LIM_WR = CW'(MAX_FRAME - 4);
  localparam logic [CW+2:0] MAXF = (CW+3)'(MAX_FRAME);

  typedef enum logic [3:0] {S_IDLE, S_DISC, S_RD0, S_RD1, S_GET, S_PUT,
                            S_WR, S_CLOSE, S_DROP, S_ARM} st_t;
  st_t st;

  logic [31:0]   base, ptr, bufsz, ctrl, w0, bufa, crc;
  logic [1:0]    evt, mask, pad_left, crc_idx;
  logic          active, arm_pend, shift16, phase_crc, final_q, close_fin;
  logic          buf_open, err_tr, err_lg;
  logic [7:0]    byte_q;
  logic [15:0]   fill;
  logic [CW-1:0] cnt;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    for (int i = 0; i < 8; i++) c = (c >> 1) ^ (32'hEDB8_8320 & {32{c[0] ^ d[i]}});
    return c;
  endfunction

  wire idle = (st == S_IDLE);

  logic [CW+2:0] fsize, fsize_cut;
  logic tr_n, lg_n;
  assign fsize     = {3'b000, cnt} + (CW+3)'(5);
  assign tr_n      = fsize > MAXF;
  assign fsize_cut = tr_n ? MAXF : fsize;
  assign lg_n      = tr_n || (fsize_cut > {{(CW-13){1'b0}}, ctrl[31:16]});

  logic [31:0] fcs;
  assign fcs = ~crc;

  assign in_ready = (st == S_GET && pad_left == 2'd0 && !phase_crc) ||
                    st == S_DISC || st == S_DROP ||
                    (idle && !active && !arm_pend);

  wire [31:0] wr_byte_addr = bufa + {16'b0, fill};
  wire [31:0] close_word = (w0 & ~(M_E | 32'h0000_FFFF)) |
                           (close_fin ? (M_L | (err_tr ? M_TR : 32'h0) | (err_lg ? M_LG : 32'h0)) : 32'h0) |
                           {16'b0, fill};

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr;
    mem_wdata = close_word;
    mem_be    = 4'hF;
    case (st)
      S_RD0, S_ARM: mem_req = 1'b1;
      S_RD1: begin mem_req = 1'b1; mem_addr = ptr + 32'd4; end
      S_WR: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = wr_byte_addr;
        mem_wdata = {4{byte_q}};
        mem_be = 4'b0001 << wr_byte_addr[1:0];
      end
      S_CLOSE: begin mem_req = 1'b1; mem_we = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    case (reg_addr)
      A_BASE:  reg_rdata = base;
      A_BUFSZ: reg_rdata = bufsz;
      A_CTRL:  reg_rdata = ctrl;
      A_ACT:   reg_rdata = {7'b0, active, 24'b0};
      A_EVT:   reg_rdata = {6'b0, evt, 24'b0};
      A_MASK:  reg_rdata = {6'b0, mask, 24'b0};
      A_OPT:   reg_rdata = {31'b0, shift16};
      default: reg_rdata = 32'b0;
    endcase
  end

  assign irq_o = |(evt & mask);

  wire [1:0] evt_clr = (reg_we && reg_addr == A_EVT) ? reg_wdata[25:24] : 2'b00;
  wire [1:0] evt_set = (st == S_CLOSE && mem_ack) ? (close_fin ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      base <= '0; ptr <= '0; bufsz <= 32'h0000_0600; ctrl <= 32'h05EE_0001;
      w0 <= '0; bufa <= '0; crc <= '1;
      evt <= '0; mask <= '0; pad_left <= '0; crc_idx <= '0;
      active <= 1'b0; arm_pend <= 1'b0; shift16 <= 1'b0; phase_crc <= 1'b0;
      final_q <= 1'b0; close_fin <= 1'b0; buf_open <= 1'b0;
      err_tr <= 1'b0; err_lg <= 1'b0; byte_q <= '0; fill <= '0; cnt <= '0;
    end else begin
      evt <= (evt & ~evt_clr) | evt_set;
      if (reg_we) begin
        case (reg_addr)
          A_BASE:  begin base <= reg_wdata & ~32'h7; ptr <= reg_wdata & ~32'h7; end
          A_BUFSZ: bufsz <= reg_wdata & 32'h0000_3FF0;
          A_CTRL:  ctrl <= reg_wdata & 32'h07FF_003F;
          A_ACT:   if (!active) arm_pend <= 1'b1;
          A_MASK:  mask <= reg_wdata[25:24];
          A_OPT:   shift16 <= reg_wdata[0];
          default: ;
        endcase
      end
      case (st)
        S_IDLE: begin
          if (arm_pend) st <= S_ARM;
          else if (in_valid) begin
            if (active) begin
              crc <= '1; cnt <= '0; pad_left <= shift16 ? 2'd2 : 2'd0;
              phase_crc <= 1'b0; crc_idx <= '0; final_q <= 1'b0;
              buf_open <= 1'b0; err_tr <= 1'b0; err_lg <= 1'b0;
              st <= S_GET;
            end else if (!in_last) st <= S_DISC;
          end
        end
        S_DISC: if (in_valid && in_last) st <= S_IDLE;
        S_GET: begin
          if (pad_left != 2'd0) begin
            byte_q <= 8'h00; pad_left <= pad_left - 2'd1; cnt <= cnt + 1'b1;
            final_q <= 1'b0; st <= S_PUT;
          end else if (!phase_crc) begin
            if (in_valid) begin
              crc <= crc_step(crc, in_data);
              cnt <= cnt + 1'b1;
              if (in_last) begin
                phase_crc <= 1'b1; err_tr <= tr_n; err_lg <= lg_n;
              end
              if (cnt < LIM_WR) begin
                byte_q <= in_data; final_q <= 1'b0; st <= S_PUT;
              end
            end
          end else begin
            byte_q <= fcs[{crc_idx, 3'b000} +: 8];
            final_q <= (crc_idx == 2'd3);
            crc_idx <= crc_idx + 2'd1;
            st <= S_PUT;
          end
        end
        S_PUT: begin
          if (!buf_open) st <= S_RD0;
          else if (fill == bufsz[15:0]) begin close_fin <= 1'b0; st <= S_CLOSE; end
          else st <= S_WR;
        end
        S_WR: if (mem_ack) begin
          fill <= fill + 16'd1;
          close_fin <= final_q;
          st <= final_q ? S_CLOSE : S_GET;
        end
        S_CLOSE: if (mem_ack) begin
          buf_open <= 1'b0;
          ptr <= w0[B_W] ? base : ptr + 32'd8;
          st <= close_fin ? S_ARM : S_RD0;
        end
        S_RD0: if (mem_ack) begin
          w0 <= mem_rdata;
          st <= mem_rdata[B_E] ? S_RD1 : (phase_crc ? S_ARM : S_DROP);
        end
        S_RD1: if (mem_ack) begin
          bufa <= mem_rdata; buf_open <= 1'b1; fill <= '0; st <= S_PUT;
        end
        S_DROP: if (in_valid && in_last) st <= S_ARM;
        S_ARM: if (mem_ack) begin
          active <= mem_rdata[B_E]; arm_pend <= 1'b0; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module rx_ring_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [3:0]  mem_be,
  input logic        in_valid,
  input logic        in_ready,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic [1:0]  evt,
  input logic [31:0] bufsz,
  input logic [15:0] fill,
  input logic        active,
  input logic        idle
);
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  assert_byte_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_be != 4'hF |-> $countones(mem_be) == 1);
  assert_fill_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_be != 4'hF |-> fill < bufsz[15:0]);
  assert_bufsz_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bufsz & ~32'h0000_3FF0) == 32'h0);
  assert_evt_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == 3'd4) |=> ($past(evt) & ~evt) == 2'b00);
  assert_discard_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    idle && !active && in_valid && in_ready |=> !mem_req);
  assert_arm_from_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(mem_req && mem_ack && !mem_we));
endmodule

bind rx_ring_engine rx_ring_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
  .in_valid(in_valid), .in_ready(in_ready), .reg_we(reg_we), .reg_addr(reg_addr),
  .evt(evt), .bufsz(bufsz), .fill(fill), .active(active), .idle(idle)
);

// File: tb/rx_ring_engine_tb_top.sv
module rx_ring_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXF = 128;
  localparam int ND = 6;
  localparam logic [31:0] RING = 32'h100;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 32'h0;
  logic [3:0]  mem_be;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'h0, reg_rdata;
  logic        irq_o;

  rx_ring_engine #(.MAX_FRAME(MAXF), .CW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o));

  logic [7:0] dmem [0:4095];
  logic [7:0] emem [0:4095];
  logic [7:0] fr [0:255];
  int n_chk = 0, n_fail = 0;

  logic [31:0] r_ptr;
  logic        r_active;
  logic [1:0]  r_evt, r_mask;
  int          r_bufsz, r_lim;
  logic        r_sh;

  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (mem_req && $urandom_range(0, 2) != 0) begin
      int a;
      a = int'(mem_addr[11:2]) * 4;
      mem_ack = 1'b1;
      if (mem_we) begin
        for (int b = 0; b < 4; b++) if (mem_be[b]) dmem[a+b] = mem_wdata[8*b +: 8];
      end
      mem_rdata = {dmem[a+3], dmem[a+2], dmem[a+1], dmem[a]};
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] erd32(input logic [31:0] a);
    return {emem[a+3], emem[a+2], emem[a+1], emem[a]};
  endfunction
  task automatic ewr32(input logic [31:0] a, input logic [31:0] d);
    for (int b = 0; b < 4; b++) emem[a+b] = d[8*b +: 8];
  endtask
  task automatic both_wr32(input logic [31:0] a, input logic [31:0] d);
    for (int b = 0; b < 4; b++) begin emem[a+b] = d[8*b +: 8]; dmem[a+b] = d[8*b +: 8]; end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] crc_ref(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++)
        c = c[0] ^ fr[i][k] ? (c >> 1) ^ 32'hEDB8_8320 : (c >> 1);
    return ~c;
  endfunction

  task automatic recycle();
    for (int i = 0; i < ND; i++) begin
      both_wr32(RING + 8*i, 32'h8000_0000 | (i == ND-1 ? 32'h2000_0000 : 32'h0));
      both_wr32(RING + 8*i + 4, 32'h400 + 32'h100*i);
    end
  endtask

  task automatic ref_frame(input int len);
    logic [7:0] ob [0:511];
    int nb, size, rem, pos, pad, ch;
    bit tr, lg;
    logic [31:0] fcs, w0, ba, nw;
    if (!r_active) return;
    pad = r_sh ? 2 : 0;
    nb = pad + len;
    size = nb + 4;
    tr = size > MAXF;
    if (tr) size = MAXF;
    lg = tr || size > r_lim;
    fcs = crc_ref(len);
    for (int i = 0; i < size - 4; i++) ob[i] = (i < pad) ? 8'h00 : fr[i - pad];
    for (int i = 0; i < 4; i++) ob[size - 4 + i] = fcs[8*i +: 8];
    rem = size; pos = 0;
    while (rem > 0) begin
      w0 = erd32(r_ptr);
      if (!w0[31]) break;
      ba = erd32(r_ptr + 4);
      ch = rem < r_bufsz ? rem : r_bufsz;
      for (int i = 0; i < ch; i++) emem[ba + i] = ob[pos + i];
      pos += ch; rem -= ch;
      nw = (w0 & 32'h7FFF_0000) | ch;
      if (rem == 0) begin
        nw |= 32'h0800_0000 | (tr ? 32'h0001_0000 : 0) | (lg ? 32'h0020_0000 : 0);
        r_evt[1] = 1'b1;
      end else r_evt[0] = 1'b1;
      ewr32(r_ptr, nw);
      r_ptr = w0[29] ? RING : r_ptr + 8;
    end
    r_active = erd32(r_ptr)[31];
  endtask

  task automatic send_frame(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = fr[i]; in_last = (i == len - 1);
      forever begin
        #1;
        if (in_ready) begin @(posedge clk); break; end
        @(negedge clk);
      end
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic verify(input string tag);
    logic [31:0] v;
    int bad = -1;
    for (int i = 0; i < 4096; i++) if (bad < 0 && dmem[i] !== emem[i]) bad = i;
    check(bad < 0, {tag, " memory image"}, bad < 0 ? 32'h0 : {dmem[bad], 12'h0, 12'(bad)},
          bad < 0 ? 32'h0 : {emem[bad], 12'h0, 12'(bad)});
    reg_rd(3'd4, v);
    check(v == {6'b0, r_evt, 24'b0}, {tag, " R5 events"}, v, {6'b0, r_evt, 24'b0});
    check(irq_o == |(r_evt & r_mask), {tag, " R13 irq"}, 32'(irq_o), 32'(|(r_evt & r_mask)));
    reg_rd(3'd3, v);
    check(v[24] == r_active, {tag, " R11 active"}, 32'(v[24]), 32'(r_active));
    reg_wr(3'd4, 32'h0300_0000);
    r_evt = 2'b00;
  endtask

  task automatic run_frame(input int len, input bit sh, input int bsz, input string tag);
    if (sh != r_sh) begin reg_wr(3'd6, 32'(sh)); r_sh = sh; end
    if (bsz != r_bufsz) begin reg_wr(3'd1, 32'(bsz)); r_bufsz = bsz; end
    for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
    ref_frame(len);
    send_frame(len);
    repeat (300) @(negedge clk);
    verify(tag);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) begin dmem[i] = 8'h00; emem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    reg_rd(3'd2, v); check(v == 32'h05EE_0001, "R1 ctrl reset", v, 32'h05EE_0001);
    reg_rd(3'd1, v); check(v == 32'h0000_0600, "R1 bufsz reset", v, 32'h600);
    reg_rd(3'd3, v); check(v == 32'h0, "R1 active reset", v, 32'h0);
    reg_rd(3'd4, v); check(v == 32'h0, "R1 events reset", v, 32'h0);
    check(irq_o == 1'b0, "R1 irq reset", 32'(irq_o), 32'h0);

    reg_wr(3'd1, 32'hFFFF_FFFF);
    reg_rd(3'd1, v); check(v == 32'h0000_3FF0, "R2 bufsz mask", v, 32'h3FF0);
    reg_wr(3'd0, 32'h0000_0107);
    reg_rd(3'd0, v); check(v == 32'h0000_0100, "R2 base mask", v, 32'h100);

    r_ptr = RING; r_evt = 2'b00; r_mask = 2'b11; r_sh = 1'b0; r_lim = 100;
    reg_wr(3'd0, RING);
    reg_wr(3'd1, 32'd32); r_bufsz = 32;
    reg_wr(3'd2, {16'd100, 16'h0001});
    reg_wr(3'd5, 32'h0300_0000);
    recycle();
    reg_wr(3'd3, 32'h0100_0000);
    repeat (20) @(negedge clk);
    r_active = 1'b1;
    reg_rd(3'd3, v); check(v[24] == 1'b1, "R11 arm by write", 32'(v[24]), 32'h1);

    run_frame(28, 1'b0, 32, "R5 exact single buffer");
    recycle();
    run_frame(29, 1'b0, 32, "R3 CRC straddle");
    recycle();
    run_frame(60, 1'b0, 32, "R4 two full buffers");
    recycle();
    run_frame(30, 1'b1, 32, "R8 zero pad");
    recycle();
    run_frame(100, 1'b0, 48, "R7 over control limit");
    recycle();
    run_frame(140, 1'b0, 32, "R6 truncated");
    recycle();
    run_frame(150, 1'b1, 48, "R6 truncated with pad");
    recycle();

    run_frame(100, 1'b0, 16, "R10 ring exhausted");
    check(r_active == 1'b0, "R10 model inactive", 32'(r_active), 32'h0);
    run_frame(40, 1'b0, 16, "R12 inactive discard");
    recycle();
    reg_wr(3'd3, 32'h0);
    repeat (20) @(negedge clk);
    r_active = erd32(r_ptr)[31];
    reg_rd(3'd3, v); check(v[24] == 1'b1, "R11 re-arm after drop", 32'(v[24]), 32'h1);

    for (int k = 0; k < 20; k++) begin
      int len, bsz;
      bsz = 16 * $urandom_range(2, 4);
      len = ($urandom_range(0, 5) == 0) ? $urandom_range(125, 160) : $urandom_range(1, 120);
      run_frame(len, 1'(($urandom_range(0, 3) == 0)), bsz, "R4 R9 random");
      recycle();
    end

    run_frame(50, 1'b0, 32, "R13 event pair");
    run_frame(10, 1'b0, 32, "R13 prep");
    r_ptr = r_ptr;
    for (int i = 0; i < 10; i++) fr[i] = 8'($urandom);
    ref_frame(10); send_frame(10); repeat (300) @(negedge clk);
    reg_wr(3'd4, 32'h0100_0000);
    r_evt[0] = 1'b0;
    reg_rd(3'd4, v); check(v == {6'b0, r_evt, 24'b0}, "R13 clear one bit", v, {6'b0, r_evt, 24'b0});
    reg_wr(3'd5, 32'h0);
    r_mask = 2'b00;
    check(irq_o == 1'b0, "R13 masked irq", 32'(irq_o), 32'h0);
    reg_wr(3'd5, 32'h0200_0000);
    r_mask = 2'b10;
    check(irq_o == r_evt[1], "R13 unmasked irq", 32'(irq_o), 32'(r_evt[1]));
    reg_wr(3'd4, 32'h0300_0000);
    r_evt = 2'b00;
    check(irq_o == 1'b0, "R13 cleared irq", 32'(irq_o), 32'h0);

    finish_run();
  end
endmodule